// File: doc/BRIEF.md
# Strided Vector Access Over Interleaved Memory Banks

This block carries out one strided vector load or store at a time against a word memory split into word-interleaved banks. A single start pulse hands it a base address, a signed stride, an element count and a load/store select. From the next cycle the address generator walks the elements in order, one candidate address per cycle. The address of element k is base plus k times stride, wrapping modulo the address space.

Each bank takes a rest period after it accepts a request. When the current element targets a bank that is still resting, the generator holds that element and issues nothing in that cycle. It never skips ahead or reorders. A stride that keeps landing on the same bank therefore slows the stream to one element per rest period, while unit stride sweeps across distinct banks at full rate.

A load returns each element's word a fixed number of cycles after it was issued, so data comes back in element order. A store writes the word on `wdata_i` in the cycle its element issues. `elem_idx_o` tells the producer which element the write data must belong to. A one-cycle completion pulse closes each operation.

Top module: `strided_bank_mem`

## Requirements
- R1: After reset, busy_o, done_o, issue_o and rvalid_o are all 0.
- R2: An address selects bank = address mod 16 (its low 4 bits) and word-in-bank = address div 16. A word stored at an address is the word later loaded from that same address.
- R3: Element k uses address (base_i + k*stride_i) mod 1024, with stride_i a 10-bit two's-complement value. Negative strides and wrap-around below address 0 are supported.
- R4: A bank that accepts a request in cycle c accepts no other request before cycle c+4. If no other stall applies, it accepts one in cycle c+4.
- R5: Elements issue strictly in order, at most one per cycle. The first candidate cycle is the cycle after the start edge. An element issues in the first cycle its bank is free, so a unit-stride run issues on consecutive cycles.
- R6: The data for a load element issued in cycle c appears on rdata_o with rvalid_o high in cycle c+12. rvalid_o is never high for a store.
- R7: A store element writes the value on wdata_i in its issue cycle. During that cycle elem_idx_o equals the element's index, counted from 0.
- R8: done_o is a one-cycle pulse, and busy_o is 0 in that cycle. It comes 2 cycles after the last store issue, or 2 cycles after the last load data cycle. With count 0 it comes 2 cycles after the cycle in which start_i was driven high.
- R9: start_i is ignored while busy_o is 1. No extra element issues and no memory word changes.
- R10: A stride that is a multiple of 16 targets one bank for every element, so elements issue exactly 4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| store_i | input | 1 | 1 = store, 0 = load, sampled with start |
| base_i | input | 10 | Address of element 0 |
| stride_i | input | 10 | Signed per-element address step |
| count_i | input | 8 | Number of elements |
| wdata_i | input | 64 | Store data for the element shown on elem_idx_o |
| issue_o | output | 1 | Current element is accepted by its bank this cycle |
| elem_idx_o | output | 8 | Index of the current element |
| rdata_o | output | 64 | Load data |
| rvalid_o | output | 1 | rdata_o holds the next element's data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps its own per-bank record of the last accepted cycle. From it, it predicts the exact issue cycle of every element, so a design that lets a resting bank accept early, stalls one cycle too long, or lets a later element overtake a stalled one shows a cycle mismatch. Runs with strides 8 and 16 force repeated same-bank conflicts, where an off-by-one rest counter is exposed. A negative stride that wraps below address 0 catches a design that treats the stride as unsigned or clamps instead of wrapping. A start pulse during a busy load, followed by a reload of the region it named, catches a design that lets start through mid-operation.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [0:0] {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } smem_op_e;
endpackage

// File: rtl/smem_bank_ctrl.sv
module smem_bank_ctrl #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_BUSY = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         issue_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  output logic [NUM_BANKS-1:0]         free_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int REST_W = (BANK_BUSY > 1) ? $clog2(BANK_BUSY) : 1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [REST_W-1:0] rest_q;
    logic              hit;
    assign hit       = issue_i && (bank_i == BANK_W'(b));
    assign free_o[b] = (rest_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              rest_q <= '0;
      else if (hit)             rest_q <= REST_W'(BANK_BUSY - 1);
      else if (rest_q != '0)    rest_q <= rest_q - 1'b1;
    end
  end

  if (BANK_BUSY > 1) begin : g_rest_chk
    // R4: the same bank is never accepted on two adjacent cycles
    a_r4_bank_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && $past(issue_i)) |-> (bank_i != $past(bank_i)));
  end
endmodule

// File: rtl/smem_bank_array.sv
module smem_bank_array #(
  parameter int NUM_BANKS = 16,
  parameter int DEPTH_W   = 6,
  parameter int DATA_W    = 64
) (
  input  logic                         clk_i,
  input  logic                         we_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic [DEPTH_W-1:0]           word_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int DEPTH  = 1 << DEPTH_W;

  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (bank_i == BANK_W'(b))) mem[word_i] <= wdata_i;
    end
    assign bank_rd[b] = mem[word_i];
  end

  assign rdata_o = bank_rd[bank_i];
endmodule

// File: rtl/smem_rd_pipe.sv
module smem_rd_pipe #(
  parameter int DATA_W  = 64,
  parameter int LATENCY = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  logic [LATENCY-1:0] v_q;
  logic [DATA_W-1:0]  d_q [LATENCY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else begin
      v_q[0] <= push_i;
      for (int i = 1; i < LATENCY; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk_i) begin
    d_q[0] <= data_i;
    for (int i = 1; i < LATENCY; i++) d_q[i] <= d_q[i-1];
  end

  assign valid_o = v_q[LATENCY-1];
  assign data_o  = d_q[LATENCY-1];
  assign busy_o  = |v_q;
endmodule

// File: rtl/smem_addr_gen.sv
module smem_addr_gen
  import smem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    store_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [ADDR_W-1:0]       stride_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [(1<<BANK_W)-1:0]  bank_free_i,
  input  logic                    pipe_busy_i,
  output logic                    issue_o,
  output logic                    store_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ADDR_W-BANK_W-1:0] word_o,
  output logic [CNT_W-1:0]        idx_o,
  output logic                    busy_o,
  output logic                    done_o
);
  logic              active_q, done_q;
  smem_op_e          op_q;
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [CNT_W-1:0]  remain_q, idx_q;
  logic              finish;

  assign bank_o  = addr_q[BANK_W-1:0];
  assign word_o  = addr_q[ADDR_W-1:BANK_W];
  assign issue_o = active_q && (remain_q != '0) && bank_free_i[bank_o];
  assign finish  = active_q && (remain_q == '0) && !pipe_busy_i;
  assign store_o = (op_q == OP_STORE);
  assign idx_o   = idx_q;
  assign busy_o  = active_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_LOAD;
      addr_q   <= '0;
      stride_q <= '0;
      remain_q <= '0;
      idx_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          op_q     <= store_i ? OP_STORE : OP_LOAD;
          addr_q   <= base_i;
          stride_q <= stride_i;
          remain_q <= count_i;
          idx_q    <= '0;
        end
      end else if (finish) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else if (issue_o) begin
        addr_q   <= addr_q + stride_q;  // modular add covers negative strides
        remain_q <= remain_q - 1'b1;
        idx_q    <= idx_q + 1'b1;
      end
    end
  end

  // R5: a stalled element keeps its address and index
  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && (remain_q != '0) && !issue_o) |=> ($stable(addr_q) && $stable(idx_q)));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R9: a start during an operation leaves the captured operation intact
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !finish && start_i) |=> ($stable(stride_q) && $stable(op_q) && active_q));
endmodule

// File: rtl/strided_bank_mem.sv
module strided_bank_mem #(
  parameter int NUM_BANKS  = 16,
  parameter int BANK_BUSY  = 4,
  parameter int RD_LATENCY = 12,
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     store_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic signed [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     issue_o,
  output logic [CNT_W-1:0]         elem_idx_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int DEPTH_W = ADDR_W - BANK_W;

  logic [NUM_BANKS-1:0] bank_free;
  logic                 pipe_busy, is_store;
  logic [BANK_W-1:0]    bank;
  logic [DEPTH_W-1:0]   word;
  logic [DATA_W-1:0]    bank_rdata;

  smem_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BANK_W(BANK_W)) u_gen (
    .clk_i, .rst_ni, .start_i, .store_i, .base_i,
    .stride_i    (ADDR_W'(stride_i)),
    .count_i,
    .bank_free_i (bank_free),
    .pipe_busy_i (pipe_busy),
    .issue_o,
    .store_o     (is_store),
    .bank_o      (bank),
    .word_o      (word),
    .idx_o       (elem_idx_o),
    .busy_o,
    .done_o
  );

  smem_bank_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_BUSY(BANK_BUSY)) u_ctrl (
    .clk_i, .rst_ni,
    .issue_i (issue_o),
    .bank_i  (bank),
    .free_o  (bank_free)
  );

  smem_bank_array #(.NUM_BANKS(NUM_BANKS), .DEPTH_W(DEPTH_W), .DATA_W(DATA_W)) u_mem (
    .clk_i,
    .we_i    (issue_o && is_store),
    .bank_i  (bank),
    .word_i  (word),
    .wdata_i,
    .rdata_o (bank_rdata)
  );

  smem_rd_pipe #(.DATA_W(DATA_W), .LATENCY(RD_LATENCY)) u_pipe (
    .clk_i, .rst_ni,
    .push_i  (issue_o && !is_store),
    .data_i  (bank_rdata),
    .valid_o (rvalid_o),
    .data_o  (rdata_o),
    .busy_o  (pipe_busy)
  );

  // R6: load data only surfaces inside a load operation
  a_r6_load_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (busy_o && !is_store));
endmodule

// File: tb/strided_bank_mem_bench.sv
module strided_bank_mem_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, store_i = 1'b0;
  logic [9:0]  base_i = '0, stride_i = '0;
  logic [7:0]  count_i = '0;
  logic [63:0] wdata_i = '0;
  logic        issue_o, rvalid_o, busy_o, done_o;
  logic [7:0]  elem_idx_o;
  logic [63:0] rdata_o;

  always #4 clk_i = ~clk_i;

  strided_bank_mem u_strided_bank_mem (
    .clk_i, .rst_ni, .start_i, .store_i, .base_i, .stride_i, .count_i, .wdata_i,
    .issue_o, .elem_idx_o, .rdata_o, .rvalid_o, .busy_o, .done_o
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  logic [63:0] ref_mem [1024];
  int          bank_last [16];
  int          addr_q[$];
  logic [63:0] exp_d[$];
  int          exp_c[$];
  int          op_id = 0, op_cnt = 0, start_cyc = 0;
  int          prev_iss = 0, last_iss = 0, last_rv = 0;
  bit          op_store = 0, done_seen = 0;
  string       tag = "R1";

  function automatic logic [63:0] pat(int op, int idx);
    return 64'hC0DE_0000_0000_0000 | (64'(op) << 32) | 64'(idx);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (issue_o) begin
        if (addr_q.size() == 0) check(0, "R9", "unexpected issue", 64'(cyc), 0);
        else begin
          int a, b, e;
          a = addr_q.pop_front();
          b = a % 16;
          e = prev_iss + 1;
          if (bank_last[b] + 4 > e) e = bank_last[b] + 4;
          check(cyc == e, tag, "issue cycle", 64'(cyc), 64'(e));
          bank_last[b] = cyc;
          prev_iss = cyc;
          last_iss = cyc;
          if (op_store) ref_mem[a] = pat(op_id, elem_idx_o);  // R7 data for this index
          else begin
            exp_d.push_back(ref_mem[a]);
            exp_c.push_back(cyc + 12);
          end
        end
      end
      if (rvalid_o) begin
        if (exp_d.size() == 0) check(0, "R6", "unexpected rvalid", 64'(cyc), 0);
        else begin
          logic [63:0] d;
          int c;
          d = exp_d.pop_front();
          c = exp_c.pop_front();
          check(rdata_o == d, "R2", {tag, " load data"}, rdata_o, d);
          check(cyc == c, "R6", "load latency", 64'(cyc), 64'(c));
          last_rv = cyc;
        end
      end
      if (done_o) begin
        int e;
        if (op_cnt == 0)   e = start_cyc + 2;
        else if (op_store) e = last_iss + 2;
        else               e = last_rv + 2;
        check(cyc == e, "R8", "done cycle", 64'(cyc), 64'(e));
        check(!busy_o, "R8", "busy at done", 64'(busy_o), 0);
        check(addr_q.size() == 0 && exp_d.size() == 0, "R5", "elements left at done",
              64'(addr_q.size() + exp_d.size()), 0);
        done_seen = 1;
      end
    end
  end

  task automatic run_op(bit st, int base, int stride, int cnt, string t, bit probe = 0);
    @(negedge clk_i);
    for (int k = 0; k < cnt; k++) addr_q.push_back(((base + k * stride) % 1024 + 1024) % 1024);
    op_id++;
    op_store  = st;
    op_cnt    = cnt;
    start_cyc = cyc;
    prev_iss  = cyc;
    done_seen = 0;
    tag       = t;
    start_i = 1; store_i = st; base_i = 10'(base); stride_i = 10'(stride); count_i = 8'(cnt);
    @(negedge clk_i);
    start_i = 0;
    for (int n = 0; !done_seen && n < 2000; n++) begin
      wdata_i = pat(op_id, elem_idx_o);
      if (probe && n == 3) begin
        check(busy_o, "R9", "busy during probe", 64'(busy_o), 1);
        start_i = 1; store_i = 1; base_i = 10'd0; stride_i = 10'd1; count_i = 8'd5;
      end else begin
        start_i = 0;
      end
      @(negedge clk_i);
    end
    start_i = 0;
    check(done_seen, "R8", {t, " done seen"}, 64'(done_seen), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bank_last[i] = -100;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !issue_o && !rvalid_o, "R1", "reset outputs",
          {busy_o, done_o, issue_o, rvalid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !issue_o && !rvalid_o, "R1", "idle after reset",
          {busy_o, done_o, issue_o, rvalid_o}, 0);

    run_op(1, 0, 1, 32, "R7");          // unit-stride store across all banks
    run_op(0, 0, 1, 32, "R5");          // unit-stride load, back to back
    run_op(1, 100, 3, 20, "R3");        // stride 3 store
    run_op(0, 100, 3, 20, "R3");
    run_op(1, 5, 16, 6, "R10");         // same bank every element
    run_op(0, 5, 16, 6, "R10");
    run_op(0, 0, 8, 4, "R4");           // two banks alternating, stalls
    run_op(1, 3, -2, 5, "R3");          // negative stride wrapping below zero
    run_op(0, 1019, 2, 5, "R3");        // read back in reverse order
    run_op(0, 31, -1, 32, "R3");        // negative unit stride
    run_op(1, 200, -32, 4, "R10");      // negative multiple of 16
    run_op(0, 200, -32, 4, "R10");
    run_op(0, 0, 1, 0, "R8");           // empty operation
    run_op(0, 8, 1, 10, "R9", 1);       // start while busy
    run_op(0, 0, 1, 8, "R9");           // region named by the probe is untouched

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule